// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block turns time-base events into two PWM output levels. A counter outside the block supplies its current value, a count-direction flag, strobes for the zero and period points, and a tick enable. Inside the block, two compare registers are matched against the counter while it counts up. Each output has its own action-control register. That register holds one 2-bit action for each of four events, and the action either does nothing, drives the output low, drives it high, or toggles it.

A continuous software force can override either output and hold it low or high. Software writes a shadow copy of the force. A reload-mode field then decides at which time-base point the shadow becomes live: at zero, at period, at either of the two, or on the next tick. Software programs everything through a simple register write port. A driver enables a channel by clearing the force. It disables a channel by forcing the output low with immediate reload.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, every register is zero and the live and shadow force are both off (reload mode zero-point).
- R2: A write stores compare A at address 0x12, compare B at 0x14, action control A at 0x16, action control B at 0x18, reload mode from data bits [7:6] at 0x1A, and the shadow force at 0x1C. A write to any other address changes nothing. A written value is used from the cycle after the write.
- R3: Action-control field positions are zero event at [1:0], period event at [3:2], compare-A-up at [5:4] and compare-B-up at [9:8]. Codes: 00 none, 01 low, 10 high, 11 toggle.
- R4: A compare-up event fires on a tick only when the counter equals that compare register and the direction flag is 1 (up). With the flag at 0 an equal counter has no effect.
- R5: When events coincide on a tick, the output takes the action of the highest-priority event whose code is not 00. The order is compare B up, then compare A up, then period, then zero.
- R6: Outputs change only on the clock edge of a cycle where tick is 1. They are visible from the cycle after that edge.
- R7: Shadow force fields are bits [1:0] for output A and bits [3:2] for output B. Code 01 holds the output low, 10 holds it high, and 00 and 11 are off. A live force overrides every event action on its output.
- R8: Reload mode 00 makes the shadow force live on a tick with the zero strobe. Mode 01 does so on a tick with the period strobe, mode 10 on a tick with either strobe, and mode 11 on any tick. At all other times the live force holds.
- R9: A force that becomes live on a tick already governs the output update of that same tick.
- R10: Action A set to zero-high, period-high and compare-A-low gives a high output from zero until the compare match. The mirrored settings give the inverted waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base advance enable |
| cntVal | input | 16 | Time-base counter value |
| cntUp | input | 1 | 1 while counting up |
| zeroEvt | input | 1 | Counter-at-zero strobe |
| prdEvt | input | 1 | Counter-at-period strobe |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 8 | Register write address |
| wrData | input | 16 | Register write data |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
The bench targets coincident events on one tick. A wrong priority chain would take the period or zero action where a compare action should win, or would let a 00 code mask a lower event. It checks equal-counter ticks while counting down, which a design ignoring the direction flag would treat as matches. It checks each reload mode, where a wrong load condition would make a force live early or late, and the same-tick use of a newly live force, where a design reading the old live copy would lag by one period. Writes to the unused address next to compare A check that a loose address decode would not corrupt the compare value.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int NUM_OUT = 2;
  localparam int ACT_W   = 10;

  localparam logic [7:0] OFF_CMPA   = 8'h12;
  localparam logic [7:0] OFF_CMPB   = 8'h14;
  localparam logic [7:0] OFF_ACTA   = 8'h16;
  localparam logic [7:0] OFF_ACTB   = 8'h18;
  localparam logic [7:0] OFF_RELOAD = 8'h1A;
  localparam logic [7:0] OFF_FORCE  = 8'h1C;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } actCode_e;

  typedef struct packed {
    logic tick;
    logic zero;
    logic prd;
    logic cmpAUp;
    logic cmpBUp;
  } evtStrobe_t;

  function automatic logic applyAct(input logic cur, input logic [1:0] code);
    case (code)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NO = NUM_OUT,
  parameter int AC = ACT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic [CW-1:0]            cntVal,
  input  logic                     cntUp,
  input  logic                     zeroEvt,
  input  logic                     prdEvt,
  input  logic                     wrEn,
  input  logic [AW-1:0]            wrAddr,
  input  logic [DW-1:0]            wrData,
  output evtStrobe_t               evt,
  output logic [NO-1:0][AC-1:0]    actCfg,
  output logic [NO-1:0][1:0]       effForce
);
  localparam int FW = 2 * NO;

  logic [CW-1:0]         cmpA, cmpB;
  logic [NO-1:0][AC-1:0] actReg;
  logic [1:0]            reloadMode;
  logic [NO-1:0][1:0]    forceShadow, forceLive;
  logic                  loadNow;

  always_comb begin
    case (reloadMode)
      2'b00:   loadNow = tick && zeroEvt;
      2'b01:   loadNow = tick && prdEvt;
      2'b10:   loadNow = tick && (zeroEvt || prdEvt);
      default: loadNow = tick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA        <= '0;
      cmpB        <= '0;
      actReg      <= '0;
      reloadMode  <= 2'b00;
      forceShadow <= '0;
      forceLive   <= '0;
    end else begin
      if (loadNow) forceLive <= forceShadow;
      if (wrEn) begin
        case (wrAddr)
          AW'(OFF_CMPA):   cmpA        <= wrData[CW-1:0];
          AW'(OFF_CMPB):   cmpB        <= wrData[CW-1:0];
          AW'(OFF_ACTA):   actReg[0]   <= wrData[AC-1:0];
          AW'(OFF_ACTB):   actReg[1]   <= wrData[AC-1:0];
          AW'(OFF_RELOAD): reloadMode  <= wrData[7:6];
          AW'(OFF_FORCE):  forceShadow <= wrData[FW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    evt.tick   = tick;
    evt.zero   = zeroEvt;
    evt.prd    = prdEvt;
    evt.cmpAUp = tick && cntUp && (cntVal == cmpA);
    evt.cmpBUp = tick && cntUp && (cntVal == cmpB);
    actCfg     = actReg;
    effForce   = loadNow ? forceShadow : forceLive;
  end

  a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(forceLive));
  a_r8_zero_mode_waits: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadMode == 2'b00 && !zeroEvt) |=> $stable(forceLive));
  a_r8_period_mode_waits: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadMode == 2'b01 && !prdEvt) |=> $stable(forceLive));
endmodule

// File: rtl/pwm_aq_datapath.sv
module pwm_aq_datapath
  import pwm_aq_pkg::*;
#(
  parameter int NO = NUM_OUT,
  parameter int AC = ACT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  evtStrobe_t            evt,
  input  logic [NO-1:0][AC-1:0] actCfg,
  input  logic [NO-1:0][1:0]    effForce,
  output logic [NO-1:0]         pwmOut
);
  for (genvar g = 0; g < NO; g++) begin : gOut
    logic [1:0] pick;
    logic       nxt;

    always_comb begin
      if (evt.cmpBUp && actCfg[g][9:8] != ACT_NONE)      pick = actCfg[g][9:8];
      else if (evt.cmpAUp && actCfg[g][5:4] != ACT_NONE) pick = actCfg[g][5:4];
      else if (evt.prd && actCfg[g][3:2] != ACT_NONE)    pick = actCfg[g][3:2];
      else if (evt.zero && actCfg[g][1:0] != ACT_NONE)   pick = actCfg[g][1:0];
      else                                               pick = ACT_NONE;

      case (effForce[g])
        2'b01:   nxt = 1'b0;
        2'b10:   nxt = 1'b1;
        default: nxt = applyAct(pwmOut[g], pick);
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)         pwmOut[g] <= 1'b0;
      else if (evt.tick) pwmOut[g] <= nxt;
    end

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
      !evt.tick |=> $stable(pwmOut[g]));
    a_r7_force_low: assert property (@(posedge clk) disable iff (!rstN)
      (evt.tick && effForce[g] == 2'b01) |=> !pwmOut[g]);
    a_r7_force_high: assert property (@(posedge clk) disable iff (!rstN)
      (evt.tick && effForce[g] == 2'b10) |=> pwmOut[g]);
  end
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntUp,
  input  logic              zeroEvt,
  input  logic              prdEvt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmA,
  output logic              pwmB
);
  evtStrobe_t                    evt;
  logic [NUM_OUT-1:0][ACT_W-1:0] actCfg;
  logic [NUM_OUT-1:0][1:0]       effForce;
  logic [NUM_OUT-1:0]            pwmOut;

  pwm_aq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cntVal(cntVal), .cntUp(cntUp),
    .zeroEvt(zeroEvt), .prdEvt(prdEvt), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .evt(evt), .actCfg(actCfg), .effForce(effForce)
  );

  pwm_aq_datapath uDp (
    .clk(clk), .rstN(rstN), .evt(evt), .actCfg(actCfg),
    .effForce(effForce), .pwmOut(pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];
endmodule

// File: tb/tb_pwm_action_qual.sv
module tb_pwm_action_qual;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, cntUp = 1'b0, zeroEvt = 1'b0, prdEvt = 1'b0, wrEn = 1'b0;
  logic [15:0] cntVal = '0, wrData = '0;
  logic [7:0]  wrAddr = '0;
  logic        pwmA, pwmB;
  int          nChk = 0, nBad = 0;

  logic [15:0] mCmpA, mCmpB;
  logic [9:0]  mAct [2];
  logic [1:0]  mMode;
  logic [1:0]  mShadow [2], mLive [2];
  logic        mOut [2];

  always #2 clk = ~clk;

  pwm_action_qual dut (.*);

  function automatic logic doAct(input logic cur, input logic [1:0] c);
    return (c == 2'b01) ? 1'b0 : (c == 2'b10) ? 1'b1 : (c == 2'b11) ? ~cur : cur;
  endfunction

  function automatic logic [1:0] pickAct(input logic [9:0] a, input logic cb,
                                         input logic ca, input logic pr, input logic zr);
    if (cb && a[9:8] != 0) return a[9:8];
    if (ca && a[5:4] != 0) return a[5:4];
    if (pr && a[3:2] != 0) return a[3:2];
    if (zr && a[1:0] != 0) return a[1:0];
    return 2'b00;
  endfunction

  task automatic modelReset();
    mCmpA = 0; mCmpB = 0; mAct[0] = 0; mAct[1] = 0; mMode = 0;
    mShadow[0] = 0; mShadow[1] = 0; mLive[0] = 0; mLive[1] = 0;
    mOut[0] = 0; mOut[1] = 0;
  endtask

  task automatic check(input string tag, input logic act, input logic exp, input int ch);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s out%0d actual=%b expected=%b at %0t", tag, ch, act, exp, $time);
    end
  endtask

  // one clock: predict from current drive, clock, compare at negedge
  task automatic step(input string tagIn);
    logic load, ca, cb;
    logic [1:0] eff [2];
    string tag;
    case (mMode)
      2'b00: load = tick && zeroEvt;
      2'b01: load = tick && prdEvt;
      2'b10: load = tick && (zeroEvt || prdEvt);
      default: load = tick;
    endcase
    ca = tick && cntUp && cntVal == mCmpA;
    cb = tick && cntUp && cntVal == mCmpB;
    tag = tagIn;
    for (int i = 0; i < 2; i++) begin
      eff[i] = load ? mShadow[i] : mLive[i];
      if (tag == "") tag = !tick ? "R6" : (eff[i] == 1 || eff[i] == 2) ? "R7" : "R5";
      if (tick) begin
        if (eff[i] == 2'b01) mOut[i] = 0;
        else if (eff[i] == 2'b10) mOut[i] = 1;
        else mOut[i] = doAct(mOut[i], pickAct(mAct[i], cb, ca, prdEvt, zeroEvt));
      end
      if (load) mLive[i] = mShadow[i];
    end
    if (wrEn) begin
      case (wrAddr)
        8'h12: mCmpA = wrData;
        8'h14: mCmpB = wrData;
        8'h16: mAct[0] = wrData[9:0];
        8'h18: mAct[1] = wrData[9:0];
        8'h1A: mMode = wrData[7:6];
        8'h1C: begin mShadow[0] = wrData[1:0]; mShadow[1] = wrData[3:2]; end
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, pwmA, mOut[0], 0);
    check(tag, pwmB, mOut[1], 1);
    wrEn = 0; tick = 0; zeroEvt = 0; prdEvt = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
    wrEn = 1; wrAddr = a; wrData = d;
    step(tag);
  endtask

  task automatic tk(input logic [15:0] c, input logic up, input logic z,
                    input logic p, input string tag);
    tick = 1; cntVal = c; cntUp = up; zeroEvt = z; prdEvt = p;
    step(tag);
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [8];
    addrs = '{8'h12, 8'h14, 8'h16, 8'h18, 8'h1A, 8'h1C, 8'h13, 8'h20};
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1", pwmA, 1'b0, 0);
    check("R1", pwmB, 1'b0, 1);
    tk(0, 1, 1, 1, "R1");        // zero registers and force off: nothing moves

    // R10 normal polarity on A: zero high, period high, compare A up low
    wr(8'h12, 16'd3, "R2");
    wr(8'h16, 16'h001A, "R10");
    for (int c = 0; c < 8; c++) tk(c[15:0], 1, c == 0, c == 7, "R10");
    // inverted polarity
    wr(8'h16, 16'h0025, "R10");
    for (int c = 0; c < 8; c++) tk(c[15:0], 1, c == 0, c == 7, "R10");

    // R2 neighbour address must not alter compare A
    wr(8'h13, 16'd5, "R2");
    wr(8'h16, 16'h0030, "R2");   // compare A up toggles
    tk(5, 1, 0, 0, "R2");
    tk(3, 1, 0, 0, "R2");

    // R4 equal counter while counting down
    tk(3, 0, 0, 0, "R4");
    tk(3, 1, 0, 0, "R4");

    // R3 toggle at zero on B, low on compare B
    wr(8'h18, 16'h0103, "R3");
    wr(8'h14, 16'd6, "R3");
    tk(0, 1, 1, 0, "R3");
    tk(0, 1, 1, 0, "R3");
    tk(6, 1, 0, 0, "R3");

    // R5 coincident events: compare wins over period and zero
    wr(8'h16, 16'h0229, "R5");   // cbu high, cau high, prd high, zero low
    wr(8'h12, 16'd2, "R5");
    wr(8'h14, 16'd2, "R5");
    tk(2, 1, 1, 1, "R5");
    wr(8'h16, 16'h0009, "R5");   // only prd high, zero low
    tk(2, 1, 1, 1, "R5");

    // R8 reload modes, R7 force, R9 same-tick effect
    wr(8'h1A, 16'h0000, "R8");
    wr(8'h1C, 16'h0009, "R8");   // A low, B high (shadow)
    tk(1, 1, 0, 1, "R8");        // mode 00 ignores period
    tk(0, 1, 1, 0, "R9");        // loads at zero, applies same tick
    tk(2, 1, 0, 1, "R7");
    wr(8'h1C, 16'h0006, "R8");   // A high, B low
    wr(8'h1A, 16'h0040, "R8");   // mode 01
    tk(0, 1, 1, 0, "R8");
    tk(4, 1, 0, 1, "R8");
    wr(8'h1C, 16'h000F, "R7");   // code 11 is off on both
    wr(8'h1A, 16'h0080, "R8");   // mode 10
    tk(4, 1, 0, 0, "R8");
    tk(0, 1, 1, 0, "R8");
    wr(8'h1C, 16'h0001, "R9");
    wr(8'h1A, 16'h00C0, "R9");   // immediate
    tk(7, 1, 0, 0, "R9");
    wr(8'h1C, 16'h0000, "R7");
    tk(7, 1, 0, 0, "R7");
    step("R6");                  // no tick: hold

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      wrEn = ($urandom % 4) == 0;
      wrAddr = addrs[$urandom % 8];
      wrData = $urandom;
      if (wrAddr == 8'h12 || wrAddr == 8'h14) wrData = wrData % 8;
      tick = ($urandom % 4) != 0;
      cntVal = $urandom % 8;
      cntUp = $urandom % 2;
      zeroEvt = ($urandom % 6) == 0;
      prdEvt = ($urandom % 6) == 0;
      step("");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule